// File: doc/BRIEF.md
# Bidirectional Port with Power-Down Wake

This block is an eight-pin general-purpose I/O port for a small microcontroller. Four eight-bit registers control it: an output data latch, a direction register, a pull-up select register and a wake select register. Software reaches them over a simple register bus. The bus can write a whole byte, or it can set or clear one bit without touching the other bits. The port drives an output value, an output enable and a pull-up enable to each pad. It also samples the pad levels through a two-flop synchroniser.

While the power-down input is held high, a small state machine watches for falling edges on the pins chosen for wake-up and raises a one-cycle wake pulse. The machine has three states:

- RUN: the device is awake.
- SLEEP: the port is armed and watching for a qualifying falling edge.
- WAKE: the pulse cycle.

Its transitions are:

- GO_SLEEP: RUN to SLEEP, when power-down is high.
- RESUME: SLEEP to RUN, when power-down is low.
- EDGE_HIT: SLEEP to WAKE, when power-down is high and a qualifying falling edge is seen.
- REARM: WAKE to SLEEP, when power-down is still high.
- WAKE_DONE: WAKE to RUN, when power-down has dropped.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset the direction register reads 8'hFF. The data, pull-up select and wake select registers read 8'h00. pad_oe, pad_pu and wake_o are all 0.
- R2: bus_addr selects a register: 0 is data, 1 is direction, 2 is pull-up select, 3 is wake select. With bus_en high, bus_op 0 writes bus_wdata into the selected register at the clock edge. bus_op 3 changes nothing.
- R3: bus_op 1 sets, and bus_op 2 clears, bit bus_bit of the selected register. The other seven bits keep their values.
- R4: A direction bit of 1 makes its pin an input and a 0 makes it an output. pad_oe[i] equals the inverse of direction bit i from the cycle after the write edge.
- R5: bus_rdata returns the selected register. For the data address, it returns the synchronised pad level on input pins and the latched value on output pins. A pad change appears there after two clock edges.
- R6: A data write updates the output latch on input pins too. pad_out always shows the latch, so the value drives the pad once the pin becomes an output.
- R7: pad_pu[i] is 1 only when pull-up select bit i is 1 and pin i is an input.
- R8: When power-down is high, the state is SLEEP, and a pin whose wake select bit and direction bit are both 1 falls from 1 to 0, wake_o goes high after the third clock edge that follows the pad change.
- R9: wake_o lasts exactly one cycle for each qualifying edge.
- R10: No wake pulse comes from a falling edge when power-down is low, on a pin that is not selected, on an output pin, or from a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_op | input | 2 | 0 write byte, 1 set bit, 2 clear bit, 3 no operation |
| bus_addr | input | 2 | Register select |
| bus_bit | input | BIT_W (3) | Bit index for set and clear |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Read data for bus_addr |
| pad_in | input | WIDTH (8) | Pad input levels |
| pad_out | output | WIDTH (8) | Pad output values |
| pad_oe | output | WIDTH (8) | Pad output enables |
| pad_pu | output | WIDTH (8) | Pull-up enables |
| pwr_down | input | 1 | Power-down indication |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The hardest case to reach is a wake pulse with exact timing. It needs the machine already in SLEEP, a pin that is both selected and an input, and a pad that has been high long enough to fill the synchroniser before it falls. The bench first programs direction and wake select over the bus and holds the pads high for several cycles. It then raises power-down and waits before dropping one pad bit at a falling clock edge. It checks wake_o after each of the next four edges. The same setup is then disturbed one way at a time (unselected pin, output pin, rising edge, power-down low) to show that no pulse appears.

// File: rtl/gpio_wake_pkg.sv
`timescale 1ns/1ps
package gpio_wake_pkg;
    localparam int NREG = 4;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_NOP = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        RA_DATA = 2'd0,
        RA_DIR  = 2'd1,
        RA_PULL = 2'd2,
        RA_WAKE = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } wake_st_e;
endpackage

// File: rtl/gpio_wake_regs.sv
`timescale 1ns/1ps
module gpio_wake_regs
    import gpio_wake_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int BIT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic [1:0]       bus_op,
    input  logic [1:0]       bus_addr,
    input  logic [BIT_W-1:0] bus_bit,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic [WIDTH-1:0] pin_level,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] wsel_q
);
    logic [WIDTH-1:0] regs_q [NREG];
    logic [WIDTH-1:0] bit_mask;
    bus_op_e          op;

    assign op       = bus_op_e'(bus_op);
    assign bit_mask = {{(WIDTH-1){1'b0}}, 1'b1} << bus_bit;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [WIDTH-1:0] RST_VAL = (g == int'(RA_DIR)) ? '1 : '0;
        logic             hit;
        logic [WIDTH-1:0] nxt;

        assign hit = bus_en && (bus_addr == 2'(g));

        always_comb begin
            nxt = regs_q[g];
            if (hit) begin
                unique case (op)
                    OP_WR:   nxt = bus_wdata;
                    OP_SET:  nxt = regs_q[g] | bit_mask;
                    OP_CLR:  nxt = regs_q[g] & ~bit_mask;
                    OP_NOP:  nxt = regs_q[g];
                    default: nxt = regs_q[g];
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= RST_VAL;
            else        regs_q[g] <= nxt;
        end
    end

    assign data_q = regs_q[RA_DATA];
    assign dir_q  = regs_q[RA_DIR];
    assign pull_q = regs_q[RA_PULL];
    assign wsel_q = regs_q[RA_WAKE];

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            RA_DATA: bus_rdata = (dir_q & pin_level) | (~dir_q & data_q);
            RA_DIR:  bus_rdata = dir_q;
            RA_PULL: bus_rdata = pull_q;
            RA_WAKE: bus_rdata = wsel_q;
            default: bus_rdata = '0;
        endcase
    end

    // R3: a set touches only the addressed bit, and that bit ends up high
    p_set_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && op == OP_SET) |=>
            (((regs_q[$past(bus_addr)] ^ $past(regs_q[bus_addr])) & ~$past(bit_mask)) == '0)
            && ((regs_q[$past(bus_addr)] & $past(bit_mask)) != '0));

    // R3: a clear touches only the addressed bit, and that bit ends up low
    p_clr_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && op == OP_CLR) |=>
            (((regs_q[$past(bus_addr)] ^ $past(regs_q[bus_addr])) & ~$past(bit_mask)) == '0)
            && ((regs_q[$past(bus_addr)] & $past(bit_mask)) == '0));

    // R2: no-operation code leaves the addressed register unchanged
    p_nop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && op == OP_NOP) |=> regs_q[$past(bus_addr)] == $past(regs_q[bus_addr]));
endmodule

// File: rtl/gpio_wake_sync.sv
`timescale 1ns/1ps
module gpio_wake_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= pad_in[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign level[i] = s2_q;
        assign fall[i]  = s3_q & ~s2_q;
    end
endmodule

// File: rtl/gpio_wake_fsm.sv
`timescale 1ns/1ps
module gpio_wake_fsm
    import gpio_wake_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic [WIDTH-1:0] fall,
    input  logic [WIDTH-1:0] armed_pins,
    output logic             wake_o
);
    wake_st_e state_q, state_d;
    logic     edge_hit;

    assign edge_hit = |(fall & armed_pins);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (pwr_down) state_d = ST_SLEEP;          // GO_SLEEP
            ST_SLEEP: if (!pwr_down) state_d = ST_RUN;           // RESUME
                      else if (edge_hit) state_d = ST_WAKE;      // EDGE_HIT
            ST_WAKE:  state_d = pwr_down ? ST_SLEEP : ST_RUN;    // REARM / WAKE_DONE
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        wake_o = 1'b0;
        unique case (state_q)
            ST_WAKE:  wake_o = 1'b1;
            ST_RUN,
            ST_SLEEP: wake_o = 1'b0;
            default:  wake_o = 1'b0;
        endcase
    end

    // R9: pulse is one cycle wide
    p_wake_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R10: a pulse always follows a cycle of power-down and a qualifying edge
    p_wake_needs_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(pwr_down) && $past(edge_hit));
endmodule

// File: rtl/gpio_wake_port.sv
`timescale 1ns/1ps
module gpio_wake_port
    import gpio_wake_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int BIT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic [1:0]       bus_op,
    input  logic [1:0]       bus_addr,
    input  logic [BIT_W-1:0] bus_bit,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu,
    input  logic             pwr_down,
    output logic             wake_o
);
    logic [WIDTH-1:0] level, fall;
    logic [WIDTH-1:0] data_q, dir_q, pull_q, wsel_q;

    gpio_wake_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .level(level), .fall(fall)
    );

    gpio_wake_regs #(.WIDTH(WIDTH), .BIT_W(BIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
        .pin_level(level), .bus_rdata(bus_rdata),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q), .wsel_q(wsel_q)
    );

    gpio_wake_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .fall(fall),
        .armed_pins(wsel_q & dir_q), .wake_o(wake_o)
    );

    assign pad_out = data_q;
    assign pad_oe  = ~dir_q;
    assign pad_pu  = pull_q & dir_q;

    // R7: a pull-up is never enabled on a driven pin
    p_pu_inputs_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R4: a byte write to direction sets the enables on the next cycle
    p_oe_follows_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_op == 2'd0 && bus_addr == 2'd1) |=> pad_oe == ~$past(bus_wdata));

    // R6: pad_out tracks a byte write to the data latch, whatever the direction
    p_out_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_op == 2'd0 && bus_addr == 2'd0) |=> pad_out == $past(bus_wdata));
endmodule

// File: tb/gpio_wake_port_test.sv
`timescale 1ns/1ps
module gpio_wake_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic [1:0] bus_op = 2'd3;
    logic [1:0] bus_addr = 2'd0;
    logic [2:0] bus_bit = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_drv = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic       pwr_down = 1'b0;
    logic       wake_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_wake_port uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_drv), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pwr_down(pwr_down), .wake_o(wake_o)
    );

    // {op[1:0], addr[1:0], bit[2:0], wdata[7:0], expected read[7:0]}
    localparam int NVEC = 13;
    localparam logic [22:0] VEC [NVEC] = '{
        {2'd0, 2'd1, 3'd0, 8'h0F, 8'h0F},
        {2'd1, 2'd1, 3'd7, 8'h00, 8'h8F},
        {2'd2, 2'd1, 3'd0, 8'h00, 8'h8E},
        {2'd0, 2'd2, 3'd0, 8'hA5, 8'hA5},
        {2'd2, 2'd2, 3'd5, 8'h00, 8'h85},
        {2'd1, 2'd2, 3'd1, 8'h00, 8'h87},
        {2'd0, 2'd3, 3'd0, 8'h3C, 8'h3C},
        {2'd3, 2'd3, 3'd2, 8'hFF, 8'h3C},
        {2'd1, 2'd3, 3'd0, 8'h00, 8'h3D},
        {2'd0, 2'd1, 3'd0, 8'h00, 8'h00},
        {2'd0, 2'd0, 3'd0, 8'h5A, 8'h5A},
        {2'd1, 2'd0, 3'd0, 8'h00, 8'h5B},
        {2'd2, 2'd0, 3'd6, 8'h00, 8'h1B}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_op_do(input logic [1:0] op, input logic [1:0] addr,
                             input logic [2:0] b, input logic [7:0] wd);
        @(negedge clk);
        bus_en = 1'b1; bus_op = op; bus_addr = addr; bus_bit = b; bus_wdata = wd;
        @(negedge clk);
        bus_en = 1'b0; bus_op = 2'd3;
        #0.5;
    endtask

    task automatic rd(input logic [1:0] addr, output logic [7:0] val);
        bus_addr = addr;
        #0.5;
        val = bus_rdata;
    endtask

    task automatic no_wake(input string req, input int n);
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (wake_o) seen = 1'b1;
        end
        chk(req, {7'd0, seen}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, r); chk("R1 dir", r, 8'hFF);
        rd(2'd0, r); chk("R1 data", r, 8'h00);
        rd(2'd2, r); chk("R1 pull", r, 8'h00);
        rd(2'd3, r); chk("R1 wsel", r, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
        chk("R1 wake", {7'd0, wake_o}, 8'h00);

        // Vector table: R2 byte writes and no-op, R3 single-bit set/clear
        for (int v = 0; v < NVEC; v++) begin
            logic [22:0] e;
            e = VEC[v];
            bus_op_do(e[22:21], e[20:19], e[18:16], e[15:8]);
            rd(e[20:19], r);
            chk((e[22:21] == 2'd1 || e[22:21] == 2'd2) ? "R3 vector" : "R2 vector", r, e[7:0]);
        end

        // R4 direction drives the enables the cycle after the write edge
        bus_op_do(2'd0, 2'd1, 3'd0, 8'hF0);
        chk("R4 oe", pad_oe, 8'h0F);

        // R6 latch written on input pins, then driven once made outputs
        bus_op_do(2'd0, 2'd1, 3'd0, 8'hFF);
        bus_op_do(2'd0, 2'd0, 3'd0, 8'hA5);
        chk("R6 out while input", pad_out, 8'hA5);
        chk("R6 oe while input", pad_oe, 8'h00);
        bus_op_do(2'd0, 2'd1, 3'd0, 8'h00);
        chk("R6 out after turn", pad_out, 8'hA5);
        chk("R6 oe after turn", pad_oe, 8'hFF);
        rd(2'd0, r); chk("R5 read outputs", r, 8'hA5);

        // R5 synchronised input read, two-edge latency, mixed directions
        bus_op_do(2'd0, 2'd1, 3'd0, 8'h0F);
        @(negedge clk); pad_drv = 8'h3C;
        @(negedge clk); rd(2'd0, r); chk("R5 one edge", r, 8'hA0);
        @(negedge clk); rd(2'd0, r); chk("R5 two edges", r, 8'hAC);

        // R7 pull-up only on inputs
        bus_op_do(2'd0, 2'd2, 3'd0, 8'hFF);
        chk("R7 pu", pad_pu, 8'h0F);

        // R8 wake from a selected input pin falling during power-down
        bus_op_do(2'd0, 2'd1, 3'd0, 8'hFF);
        bus_op_do(2'd0, 2'd3, 3'd0, 8'h04);
        pad_drv = 8'hFF;
        repeat (4) @(negedge clk);
        pwr_down = 1'b1;
        repeat (3) @(negedge clk);
        pad_drv = 8'hFB;
        @(negedge clk); chk("R8 edge1", {7'd0, wake_o}, 8'h00);
        @(negedge clk); chk("R8 edge2", {7'd0, wake_o}, 8'h00);
        @(negedge clk); chk("R8 edge3", {7'd0, wake_o}, 8'h01);
        @(negedge clk); chk("R9 single", {7'd0, wake_o}, 8'h00);
        no_wake("R9 no repeat", 4);

        // R10 unselected pin falling
        pad_drv = 8'hF3;
        no_wake("R10 unselected", 6);
        // R10 rising edge on selected pin
        pad_drv = 8'hF7;
        no_wake("R10 rising", 6);
        // R10 selected pin that is an output
        bus_op_do(2'd2, 2'd1, 3'd2, 8'h00);
        pad_drv = 8'hF3;
        no_wake("R10 output pin", 6);
        // R10 power-down low
        bus_op_do(2'd1, 2'd1, 3'd2, 8'h00);
        pad_drv = 8'hF7;
        repeat (4) @(negedge clk);
        pwr_down = 1'b0;
        repeat (2) @(negedge clk);
        pad_drv = 8'hF3;
        no_wake("R10 awake", 6);

        // R8 again to show the port still wakes after those cases
        pad_drv = 8'hF7;
        repeat (4) @(negedge clk);
        pwr_down = 1'b1;
        repeat (3) @(negedge clk);
        pad_drv = 8'hF3;
        repeat (3) @(negedge clk);
        chk("R8 second wake", {7'd0, wake_o}, 8'h01);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule